// File: doc/BRIEF.md
# CAN Standby Exit and Bus-Idle Integration Controller

This block decides when a CAN node may leave its low-power standby mode and take part in bus traffic, and when it may return to standby. Software writes a small control register holding a run request, a quick-sync choice and a wake-pulse choice. Setting the run request starts an exit sequence. If the wake-pulse choice is set, the sequence begins with one bit time of dominant level forced onto the transmit line. The block then watches the sampled receive level, one sample per bit strobe, and counts runs of recessive bits. The node is declared active after one run, or after a full set of runs, depending on the quick-sync choice.

Clearing the run request asks for standby. The switch waits until the protocol engine reports that no transfer is in progress. Until the switch happens, the run bit keeps reading back as 1. Software can therefore treat a read value of 0 as proof that the node is idle and its clocks may be stopped.

Top module: `canStandbyCtl`

## Requirements
- R1: After reset the register reads 00h, the run read-back is 0, the node is not active, and the transmit override is off with the drive level recessive (1).
- R2: With bit 2 (quick sync) at 0, the node becomes active on the clock edge that takes the 1408th recessive sample (128 runs of 11) after the exit starts. After 1407 such samples it is still inactive.
- R3: With bit 2 at 1, the node becomes active on the edge that takes the 11th consecutive recessive sample. After 10 such samples it is still inactive.
- R4: A dominant sample (receive level 0) taken during the exit count restarts the current 11-bit run from zero. Runs already completed still count.
- R5: With bit 1 (wake pulse) at 1, writing bit 0 as 1 from standby forces the transmit line dominant. The override and drive level 0 start at the first bit strobe after the write and end at the next strobe. That ending strobe's sample is not counted, and counting starts with the strobe after it.
- R6: With bit 1 at 0, an exit from standby never raises the transmit override.
- R7: Writing bit 0 as 0 while active with a transfer in progress keeps the node active and the run read-back at 1. Both fall one edge after the transfer flag is seen low.
- R8: Writing bit 0 as 0 while active with no transfer in progress gives standby (run read-back 0) two clock edges after the write.
- R9: Writing bit 0 as 1 while active, or bit 0 as 0 while in standby, changes no state. In particular, an active node raises no wake pulse.
- R10: Register read data holds the run read-back in bit 0, the wake-pulse choice in bit 1 and the quick-sync choice in bit 2. Bits 7 to 3 read 0. Bits 1 and 2 take their written values on any write.
- R11: Writing bit 0 as 0 during the exit sequence returns to standby at the next edge, even when the same edge takes the final recessive sample. A later exit starts its count from zero.
- R12: Writing bit 0 as 1 while a standby request waits on a transfer cancels the request, and the node stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe at each bit sample point |
| rxLevel | input | 1 | Sampled receive level, 1 recessive, 0 dominant |
| xferBusy | input | 1 | Protocol engine has a transfer in progress |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read-back |
| txOverride | output | 1 | Block takes over the transmit line |
| txValue | output | 1 | Level driven while overriding, 0 dominant |
| nodeActive | output | 1 | Node is integrated into the bus |
| runReadback | output | 1 | Run bit as software reads it |

## Verification
Two functions can fall into the same cycle: an abort written by software, and the recessive sample that completes the exit count. The bench runs a quick-sync exit up to ten recessive bits. It then raises the register write clearing bit 0 in the very cycle that carries the eleventh recessive strobe. The abort must win: after that edge and one cycle later the node is inactive and the run read-back is 0. A second collision is also checked. Software rewrites the run request while a standby request waits on a transfer, and the transfer flag is dropped afterwards; the node must stay active.

// File: rtl/canSbyPkg.sv
package canSbyPkg;
  // bit positions software relies on
  localparam int RUN_POS   = 0;
  localparam int WAKE_POS  = 1;
  localparam int QUICK_POS = 2;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_ALIGN   = 3'd1,
    ST_PULSE   = 3'd2,
    ST_SYNC    = 3'd3,
    ST_ACTIVE  = 3'd4,
    ST_DRAIN   = 3'd5
  } modeT;

  typedef struct packed {
    logic clear;   // hold idle counters at zero
    logic sample;  // take one bus sample this cycle
  } cntStrbT;
endpackage

// File: rtl/canSbyIdleCount.sv
module canSbyIdleCount
  import canSbyPkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int GROUPS  = 128
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntStrbT strb,
  input  logic    rxLevel,
  input  logic    quickSync,
  output logic    syncDone
);
  localparam int BW = $clog2(RUN_LEN);
  localparam int GW = $clog2(GROUPS);
  localparam logic [BW-1:0] LAST_BIT   = BW'(RUN_LEN - 1);
  localparam logic [GW-1:0] LAST_GROUP = GW'(GROUPS - 1);

  logic [BW-1:0] bitCnt;
  logic [GW-1:0] groupCnt;
  logic runEnd;

  assign runEnd   = strb.sample && rxLevel && (bitCnt == LAST_BIT);
  assign syncDone = runEnd && (quickSync || (groupCnt == LAST_GROUP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      groupCnt <= '0;
    end else if (strb.clear) begin
      bitCnt   <= '0;
      groupCnt <= '0;
    end else if (strb.sample) begin
      if (!rxLevel) begin
        bitCnt <= '0;
      end else if (runEnd) begin
        bitCnt   <= '0;
        groupCnt <= groupCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R4: a dominant sample drops the partial run but keeps finished runs
  a_r4_dominant_keeps_groups: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && !strb.clear && !rxLevel) |=> (bitCnt == '0 && groupCnt == $past(groupCnt)));

  // R2: counters never pass their limits
  a_r2_counters_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt <= LAST_BIT) && (groupCnt <= LAST_GROUP));

  // R3: completion only on a recessive sample
  a_r3_done_needs_recessive: assert property (@(posedge clk) disable iff (!rstN)
    syncDone |-> (rxLevel && strb.sample));
endmodule

// File: rtl/canSbyFsm.sv
module canSbyFsm
  import canSbyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       xferBusy,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       syncDone,
  output cntStrbT    strb,
  output logic       quickSync,
  output logic [7:0] regRdData,
  output logic       txOverride,
  output logic       txValue,
  output logic       nodeActive,
  output logic       runReadback
);
  modeT mode, modeNext;
  logic wakeEn;
  logic runSet, runClr;

  assign runSet = regWrEn &&  regWrData[RUN_POS];
  assign runClr = regWrEn && !regWrData[RUN_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn    <= 1'b0;
      quickSync <= 1'b0;
    end else if (regWrEn) begin
      wakeEn    <= regWrData[WAKE_POS];
      quickSync <= regWrData[QUICK_POS];
    end
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      ST_STANDBY: if (runSet) modeNext = regWrData[WAKE_POS] ? ST_ALIGN : ST_SYNC;
      ST_ALIGN:   if (runClr) modeNext = ST_STANDBY;
                  else if (bitTick) modeNext = ST_PULSE;
      ST_PULSE:   if (runClr) modeNext = ST_STANDBY;
                  else if (bitTick) modeNext = ST_SYNC;
      ST_SYNC:    if (runClr) modeNext = ST_STANDBY;
                  else if (syncDone) modeNext = ST_ACTIVE;
      ST_ACTIVE:  if (runClr) modeNext = ST_DRAIN;
      ST_DRAIN:   if (runSet) modeNext = ST_ACTIVE;
                  else if (!xferBusy) modeNext = ST_STANDBY;
      default:    modeNext = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= ST_STANDBY;
    else       mode <= modeNext;
  end

  always_comb begin
    strb.clear  = (mode != ST_SYNC);
    strb.sample = (mode == ST_SYNC) && bitTick && !runClr;
  end

  assign txOverride  = (mode == ST_PULSE);
  assign txValue     = ~txOverride;
  assign nodeActive  = (mode == ST_ACTIVE) || (mode == ST_DRAIN);
  assign runReadback = (mode != ST_STANDBY);

  always_comb begin
    regRdData            = '0;
    regRdData[RUN_POS]   = runReadback;
    regRdData[WAKE_POS]  = wakeEn;
    regRdData[QUICK_POS] = quickSync;
  end

  // R5: wake pulse starts on a bit strobe
  a_r5_pulse_starts_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOverride) |-> $past(bitTick));

  // R5: wake pulse ends on a bit strobe or an abort
  a_r5_pulse_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOverride) |-> ($past(bitTick) || $past(runClr)));

  // R7: never leave the bus while a transfer runs
  a_r7_no_drop_mid_transfer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nodeActive) |-> !$past(xferBusy));

  // R2: activation only follows a completed idle count
  a_r2_active_after_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nodeActive) |-> $past(syncDone));

  // R9: a clear request in standby changes nothing
  a_r9_standby_clear_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mode == ST_STANDBY && runClr) |=> (mode == ST_STANDBY));

  // R10: reserved bits never stick
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[7:3] != '0) |=> (regRdData[7:3] == '0));
endmodule

// File: rtl/canStandbyCtl.sv
module canStandbyCtl
  import canSbyPkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int GROUPS  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxLevel,
  input  logic       xferBusy,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       txOverride,
  output logic       txValue,
  output logic       nodeActive,
  output logic       runReadback
);
  cntStrbT strb;
  logic    syncDone;
  logic    quickSync;

  canSbyFsm uFsm (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .xferBusy(xferBusy),
    .regWrEn(regWrEn), .regWrData(regWrData), .syncDone(syncDone),
    .strb(strb), .quickSync(quickSync), .regRdData(regRdData),
    .txOverride(txOverride), .txValue(txValue), .nodeActive(nodeActive),
    .runReadback(runReadback)
  );

  canSbyIdleCount #(.RUN_LEN(RUN_LEN), .GROUPS(GROUPS)) uCount (
    .clk(clk), .rstN(rstN), .strb(strb), .rxLevel(rxLevel),
    .quickSync(quickSync), .syncDone(syncDone)
  );
endmodule

// File: tb/canStandbyCtl_test.sv
module canStandbyCtl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, rxLevel = 1'b1, xferBusy = 1'b0, regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic txOverride, txValue, nodeActive, runReadback;
  int totalCount = 0, failCount = 0, pulseCycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  canStandbyCtl uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLevel(rxLevel),
    .xferBusy(xferBusy), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .txOverride(txOverride), .txValue(txValue),
    .nodeActive(nodeActive), .runReadback(runReadback)
  );

  always @(negedge clk) if (txOverride) pulseCycles++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    totalCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitStep(input logic rx);
    bitTick = 1'b1; rxLevel = rx;
    @(negedge clk);
    bitTick = 1'b0; rxLevel = 1'b1;
    @(negedge clk);
  endtask

  task automatic bits(input int n, input logic rx);
    for (int i = 0; i < n; i++) bitStep(rx);
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic toStandby();
    xferBusy = 1'b0;
    wr(8'h04);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 regRdData", regRdData, 8'h00);
    check("R1 runReadback", runReadback, 1'b0);
    check("R1 nodeActive", nodeActive, 1'b0);
    check("R1 txOverride", txOverride, 1'b0);
    check("R1 txValue", txValue, 1'b1);
  endtask

  task automatic testRegBits();
    wr(8'h06);
    check("R10 readback 06", regRdData, 8'h06);
    check("R9 clear in standby", runReadback, 1'b0);
    wr(8'hF8);
    check("R10 reserved bits read zero", regRdData, 8'h00);
  endtask

  task automatic testFast();
    wr(8'h05);
    check("R10 run read-back", regRdData, 8'h05);
    bits(10, 1'b1);
    check("R3 inactive after 10", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R3 active after 11", nodeActive, 1'b1);
  endtask

  task automatic testIgnoreRun();
    pulseCycles = 0;
    wr(8'h07);
    bits(3, 1'b1);
    check("R9 still active", nodeActive, 1'b1);
    check("R9 no pulse when active", pulseCycles[7:0], 8'd0);
    check("R10 readback 07", regRdData, 8'h07);
  endtask

  task automatic testDrain();
    xferBusy = 1'b1;
    wr(8'h04);
    check("R7 readback while busy", runReadback, 1'b1);
    repeat (5) @(negedge clk);
    check("R7 still active while busy", nodeActive, 1'b1);
    xferBusy = 1'b0;
    @(negedge clk);
    check("R7 standby after transfer", runReadback, 1'b0);
    check("R7 inactive after transfer", nodeActive, 1'b0);
  endtask

  task automatic testQuickStandby();
    wr(8'h05); bits(11, 1'b1);
    check("R8 active before", nodeActive, 1'b1);
    wr(8'h04);
    check("R8 read-back 1 one edge after", runReadback, 1'b1);
    @(negedge clk);
    check("R8 standby two edges after", regRdData, 8'h04);
  endtask

  task automatic testCancel();
    wr(8'h05); bits(11, 1'b1);
    xferBusy = 1'b1;
    wr(8'h04);
    wr(8'h05);
    xferBusy = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 cancel keeps active", nodeActive, 1'b1);
    toStandby();
  endtask

  task automatic testDominantFast();
    wr(8'h05);
    bits(5, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
    check("R4 fast restart not active", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R4 fast restart active", nodeActive, 1'b1);
    toStandby();
  endtask

  task automatic testFull();
    wr(8'h01);
    bits(1407, 1'b1);
    check("R2 inactive after 1407", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R2 active after 1408", nodeActive, 1'b1);
    toStandby();
  endtask

  task automatic testDominantFull();
    wr(8'h01);
    bits(60, 1'b1); bits(1, 1'b0); bits(1352, 1'b1);
    check("R4 groups kept not yet", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R4 groups kept active", nodeActive, 1'b1);
    toStandby();
  endtask

  task automatic testWake();
    wr(8'h07);
    check("R5 no pulse before strobe", txOverride, 1'b0);
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    check("R5 override on", txOverride, 1'b1);
    check("R5 drive dominant", txValue, 1'b0);
    @(negedge clk);
    check("R5 override held", txOverride, 1'b1);
    bitStep(1'b1);
    check("R5 override off after one bit", txOverride, 1'b0);
    bits(10, 1'b1);
    check("R5 end strobe not counted", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R5 active after pulse and run", nodeActive, 1'b1);
    wr(8'h04); @(negedge clk);
  endtask

  task automatic testNoWake();
    pulseCycles = 0;
    wr(8'h05);
    bits(11, 1'b1);
    check("R6 no override", pulseCycles[7:0], 8'd0);
    check("R6 active", nodeActive, 1'b1);
    toStandby();
  endtask

  task automatic testAbort();
    wr(8'h05); bits(5, 1'b1);
    wr(8'h04);
    check("R11 abort to standby", runReadback, 1'b0);
    wr(8'h05); bits(10, 1'b1);
    check("R11 restart counts from zero", nodeActive, 1'b0);
    bits(1, 1'b1);
    check("R11 restart completes", nodeActive, 1'b1);
    toStandby();
    wr(8'h05); bits(10, 1'b1);
    bitTick = 1'b1; rxLevel = 1'b1; regWrEn = 1'b1; regWrData = 8'h04;
    @(negedge clk);
    bitTick = 1'b0; regWrEn = 1'b0;
    check("R11 abort wins over final sample", nodeActive, 1'b0);
    check("R11 abort read-back", runReadback, 1'b0);
    @(negedge clk);
    check("R11 stays standby", nodeActive, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegBits();
    testFast();
    testIgnoreRun();
    testDrain();
    testQuickStandby();
    testCancel();
    testDominantFast();
    testFull();
    testDominantFull();
    testWake();
    testNoWake();
    testAbort();
    done = 1;
    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      totalCount++; failCount++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
      $finish;
    end
  end
endmodule